// File: doc/BRIEF.md
# Link Test Pattern Generator

This block produces diagnostic traffic for a serial converter link transmitter. A three-bit mode field picks one of two kinds of pattern. Sample-level patterns (a ramp, an alternating checkerboard, or a constant word from configuration) take the place of converter samples. They leave on a sample-word stream that feeds the transport packer, so they are packed and cut into octets exactly as real samples would be. Link-level patterns (three pseudo-random bit sequences) leave on an octet stream that goes straight to the 8b/10b encoder and skips the packer. Each stream has its own enable and its own active flag.

The phase of the sample patterns is tied to the link synchronisation request. The request is active low. When it is released (low to high), every sample pattern starts again from phase zero. A receiver that times this release against the sample clock therefore sees the pattern in a known, repeatable phase. A new mode value is taken only at the last octet of a frame, so a switch never cuts a frame in two. The octet counter that marks frames also restarts when the synchronisation request is released.

Top module: `link_test_pattern_gen`

## Requirements
- R1: During reset and after it, both data outputs are zero, both active flags are low, and the active mode is off.
- R2: Mode codes 1 to 3 are sample patterns and raise `smp_valid`. Codes 4 to 6 are octet patterns and raise `oct_valid`. Codes 0 and 7 raise neither flag. The two flags are never high together. A flag follows the active mode one cycle later.
- R3: In mode 1, each accepted sample is one more than the previous sample. The value wraps from all ones to zero.
- R4: In mode 2, samples alternate between the word whose odd bits are set (0xAA at 8 bits) and its inverse. Phase zero gives the odd-bits word.
- R5: In mode 3, every accepted sample equals `cfg_user_word`.
- R6: The first cycle in which `sync_n` is seen high after being low resets the sample pattern phase. If `sample_en` is high in that same cycle, that sample already uses phase zero, so in mode 1 it is 0.
- R7: Mode 4 emits the sequence x^7+x^6+1, eight bits per accepted octet, with the first-generated bit in bit 7. The generator starts from all ones whenever the mode is entered, so the first octet is 0x02.
- R8: Mode 5 emits the sequence x^15+x^14+1 with the same bit order and all-ones start as R7.
- R9: Mode 6 emits the sequence x^31+x^28+1 with the same bit order and all-ones start as R7.
- R10: `cfg_mode` is copied into the active mode only on an accepted octet while the frame octet counter is at FRAME_OCTETS-1. The counter advances on each accepted octet and returns to zero on a synchronisation release. An out-of-range code is copied as off.
- R11: `smp_data` changes only in cycles with `sample_en` high, and `oct_data` changes only in cycles with `octet_en` high. Outside an active mode of the matching kind, an accepted word or octet is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Requested pattern mode |
| cfg_user_word | input | SAMPLE_W | Constant word used by mode 3 |
| sync_n | input | 1 | Link synchronisation request, active low |
| sample_en | input | 1 | Sample-rate enable |
| octet_en | input | 1 | Octet-rate enable |
| smp_data | output | SAMPLE_W | Sample pattern word |
| smp_valid | output | 1 | Sample pattern active |
| oct_data | output | 8 | Octet pattern to the encoder |
| oct_valid | output | 1 | Octet pattern active |

## Verification
Two events can land in the same cycle. In the sample path, a synchronisation release can coincide with an accepted sample. In the control path, a frame-boundary mode capture can coincide with a synchronisation release that clears the frame counter. The bench drives the release in a cycle with `sample_en` high in ramp mode and expects a zero sample. In the random phase it also drops and raises `sync_n` at arbitrary points while both enables run, and a cycle-level reference model, built from the requirements, predicts every output.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_RAMP    = 3'd1,
    MODE_CHECKER = 3'd2,
    MODE_USER    = 3'd3,
    MODE_PRBS7   = 3'd4,
    MODE_PRBS15  = 3'd5,
    MODE_PRBS31  = 3'd6,
    MODE_RSVD    = 3'd7
  } tpg_mode_e;

  localparam int PRBS_COUNT = 3;

  function automatic logic is_transport(tpg_mode_e m);
    return (m == MODE_RAMP) || (m == MODE_CHECKER) || (m == MODE_USER);
  endfunction

  function automatic logic is_link(tpg_mode_e m);
    return (m == MODE_PRBS7) || (m == MODE_PRBS15) || (m == MODE_PRBS31);
  endfunction

  function automatic tpg_mode_e sanitize(logic [2:0] code);
    return (code == 3'd7) ? MODE_OFF : tpg_mode_e'(code);
  endfunction

  function automatic int prbs_order(int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/tpg_frame_ctl.sv
module tpg_frame_ctl
  import tpg_pkg::*;
#(
  parameter int FRAME_OCTETS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sync_n,
  input  logic      octet_en,
  input  logic [2:0] cfg_mode,
  output logic      sync_rise,
  output tpg_mode_e act_mode
);

  localparam int CNT_W = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_OCTETS - 1);

  logic             sync_q;
  logic [CNT_W-1:0] fcnt;
  logic             frame_last;

  assign sync_rise  = sync_n & ~sync_q;
  assign frame_last = (fcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
    end else if (sync_rise) begin
      fcnt <= '0;
    end else if (octet_en) begin
      fcnt <= frame_last ? '0 : fcnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_OFF;
    end else if (octet_en && frame_last) begin
      act_mode <= sanitize(cfg_mode);
    end
  end

endmodule

// File: rtl/tpg_transport.sv
module tpg_transport
  import tpg_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_en,
  input  logic                sync_rise,
  input  tpg_mode_e           act_mode,
  input  logic [SAMPLE_W-1:0] user_word,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid
);

  function automatic logic [SAMPLE_W-1:0] odd_bits();
    logic [SAMPLE_W-1:0] v;
    for (int i = 0; i < SAMPLE_W; i++) v[i] = (i % 2) == 1;
    return v;
  endfunction

  localparam logic [SAMPLE_W-1:0] ALT = odd_bits();

  logic [SAMPLE_W-1:0] phase;
  logic [SAMPLE_W-1:0] eff_phase;
  logic [SAMPLE_W-1:0] word;

  assign eff_phase = sync_rise ? '0 : phase;

  always_comb begin
    case (act_mode)
      MODE_RAMP:    word = eff_phase;
      MODE_CHECKER: word = eff_phase[0] ? ~ALT : ALT;
      MODE_USER:    word = user_word;
      default:      word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (sample_en) begin
      phase <= eff_phase + SAMPLE_W'(1);
    end else if (sync_rise) begin
      phase <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_data  <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= is_transport(act_mode);
      if (sample_en) smp_data <= word;
    end
  end

endmodule

// File: rtl/tpg_prbs_octet.sv
module tpg_prbs_octet #(
  parameter int ORDER = 7,
  parameter int TAP   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       adv,
  output logic [7:0] octet
);

  logic [ORDER-1:0] state;
  logic [ORDER-1:0] nxt;

  always_comb begin
    logic [ORDER-1:0] t;
    logic             b;
    t = state;
    octet = '0;
    for (int i = 0; i < 8; i++) begin
      b = t[ORDER-1] ^ t[TAP-1];
      octet[7-i] = b;
      t = {t[ORDER-2:0], b};
    end
    nxt = t;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state <= '1;
    end else if (adv) begin
      state <= nxt;
    end
  end

endmodule

// File: rtl/tpg_link.sv
module tpg_link
  import tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       octet_en,
  input  tpg_mode_e  act_mode,
  output logic [7:0] oct_data,
  output logic       oct_valid
);

  logic [7:0] gen_oct [PRBS_COUNT];
  logic [7:0] sel_oct;

  for (genvar g = 0; g < PRBS_COUNT; g++) begin : g_prbs
    logic mine;
    assign mine = (act_mode == tpg_mode_e'(3'(4 + g)));
    tpg_prbs_octet #(
      .ORDER(prbs_order(g)),
      .TAP  (prbs_tap(g))
    ) u_gen (
      .clk  (clk),
      .rst  (rst),
      .clear(~mine),
      .adv  (octet_en),
      .octet(gen_oct[g])
    );
  end

  always_comb begin
    case (act_mode)
      MODE_PRBS7:  sel_oct = gen_oct[0];
      MODE_PRBS15: sel_oct = gen_oct[1];
      MODE_PRBS31: sel_oct = gen_oct[2];
      default:     sel_oct = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_data  <= '0;
      oct_valid <= 1'b0;
    end else begin
      oct_valid <= is_link(act_mode);
      if (octet_en) oct_data <= sel_oct;
    end
  end

endmodule

// File: rtl/link_test_pattern_gen.sv
module link_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int FRAME_OCTETS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          cfg_mode,
  input  logic [SAMPLE_W-1:0] cfg_user_word,
  input  logic                sync_n,
  input  logic                sample_en,
  input  logic                octet_en,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  output logic [7:0]          oct_data,
  output logic                oct_valid
);

  logic      sync_rise;
  tpg_mode_e act_mode;

  tpg_frame_ctl #(.FRAME_OCTETS(FRAME_OCTETS)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sync_n   (sync_n),
    .octet_en (octet_en),
    .cfg_mode (cfg_mode),
    .sync_rise(sync_rise),
    .act_mode (act_mode)
  );

  tpg_transport #(.SAMPLE_W(SAMPLE_W)) u_xport (
    .clk      (clk),
    .rst      (rst),
    .sample_en(sample_en),
    .sync_rise(sync_rise),
    .act_mode (act_mode),
    .user_word(cfg_user_word),
    .smp_data (smp_data),
    .smp_valid(smp_valid)
  );

  tpg_link u_link (
    .clk      (clk),
    .rst      (rst),
    .octet_en (octet_en),
    .act_mode (act_mode),
    .oct_data (oct_data),
    .oct_valid(oct_valid)
  );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                sample_en,
  input logic                octet_en,
  input logic                sync_rise,
  input logic [2:0]          act_mode,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                smp_valid,
  input logic [7:0]          oct_data,
  input logic                oct_valid
);

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && oct_valid));

  assert_smp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sample_en)) |-> $stable(smp_data));

  assert_oct_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(octet_en)) |-> $stable(oct_data));

  assert_mode_boundary_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(octet_en)) |-> $stable(act_mode));

  assert_ramp_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (sync_rise && sample_en && act_mode == 3'd1) |=> (smp_data == '0));

endmodule

bind link_test_pattern_gen tpg_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sample_en(sample_en),
  .octet_en (octet_en),
  .sync_rise(sync_rise),
  .act_mode (act_mode),
  .smp_data (smp_data),
  .smp_valid(smp_valid),
  .oct_data (oct_data),
  .oct_valid(oct_valid)
);

// File: tb/sim_link_test_pattern_gen.sv
module sim_link_test_pattern_gen;

  localparam int W  = 8;
  localparam int FO = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   cfg_mode = 3'd0;
  logic [W-1:0] cfg_user_word = 8'h3C;
  logic         sync_n = 1'b0;
  logic         sample_en = 1'b0;
  logic         octet_en = 1'b0;
  logic [W-1:0] smp_data;
  logic         smp_valid;
  logic [7:0]   oct_data;
  logic         oct_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  link_test_pattern_gen #(.SAMPLE_W(W), .FRAME_OCTETS(FO)) u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_user_word(cfg_user_word),
    .sync_n(sync_n), .sample_en(sample_en), .octet_en(octet_en),
    .smp_data(smp_data), .smp_valid(smp_valid),
    .oct_data(oct_data), .oct_valid(oct_valid)
  );

  // reference model state
  logic         m_sq;
  int           m_fc;
  int           m_mode;
  logic [W-1:0] m_ph;
  logic [30:0]  m_lf [3];
  logic [W-1:0] e_sd;
  logic         e_sv;
  logic [7:0]   e_od;
  logic         e_ov;
  int           e_mode;

  function automatic int ord(int k); return (k == 0) ? 7 : (k == 1) ? 15 : 31; endfunction
  function automatic int tap(int k); return (k == 0) ? 6 : (k == 1) ? 14 : 28; endfunction

  // produce one octet of sequence k, MSB first, advancing the state
  function automatic logic [7:0] lfsr_octet(int k, ref logic [30:0] s);
    logic [7:0] o;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      b = s[ord(k)-1] ^ s[tap(k)-1];
      o[i] = b;
      s = ((s << 1) | 31'(b)) & ((31'h7FFFFFFF) >> (31 - ord(k)));
    end
    return o;
  endfunction

  function automatic logic [W-1:0] xport_word(int md, logic [W-1:0] p);
    case (md)
      1: return p;
      2: return p[0] ? 8'h55 : 8'hAA;
      3: return cfg_user_word;
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_sq = 0; m_fc = 0; m_mode = 0; m_ph = 0;
    for (int k = 0; k < 3; k++) m_lf[k] = '1;
    e_sd = 0; e_sv = 0; e_od = 0; e_ov = 0; e_mode = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string data_tag(int md);
    case (md)
      1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R7"; 5: return "R8"; 6: return "R9";
      default: return "R11";
    endcase
  endfunction

  // one clock: inputs already driven at negedge
  task automatic step();
    logic rise;
    logic [W-1:0] eff;
    rise = sync_n && !m_sq;
    eff  = rise ? '0 : m_ph;
    e_mode = m_mode;
    if (sample_en) begin
      e_sd = xport_word(m_mode, eff);
      m_ph = eff + 8'd1;
    end else if (rise) m_ph = '0;
    e_sv = (m_mode >= 1 && m_mode <= 3);
    if (octet_en) e_od = (m_mode >= 4 && m_mode <= 6) ? lfsr_octet(m_mode - 4, m_lf[m_mode-4]) : 8'h00;
    e_ov = (m_mode >= 4 && m_mode <= 6);
    for (int k = 0; k < 3; k++) if (m_mode != k + 4) m_lf[k] = '1;
    if (octet_en && m_fc == FO - 1) m_mode = (cfg_mode == 3'd7) ? 0 : int'(cfg_mode);
    if (rise) m_fc = 0;
    else if (octet_en) m_fc = (m_fc == FO - 1) ? 0 : m_fc + 1;
    m_sq = sync_n;
    @(posedge clk);
    @(negedge clk);
    check("R2", {31'd0, smp_valid}, {31'd0, e_sv});
    check("R2", {31'd0, oct_valid}, {31'd0, e_ov});
    check(data_tag(e_mode), {24'd0, smp_data}, {24'd0, e_sd});
    check(data_tag(e_mode), {24'd0, oct_data}, {24'd0, e_od});
  endtask

  task automatic drive(logic s, logic se, logic oe);
    sync_n = s; sample_en = se; octet_en = oe;
    step();
  endtask

  // release sync (counter to 0) then give FO octets so the mode is taken
  task automatic set_mode(logic [2:0] md);
    cfg_mode = md;
    drive(0, 0, 0);
    drive(1, 0, 0);
    for (int i = 0; i < FO; i++) drive(1, 0, 1);
    drive(1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs held at zero while in reset
    check("R1", {23'd0, smp_data, smp_valid}, 32'd0);
    check("R1", {23'd0, oct_data, oct_valid}, 32'd0);
    rst = 0;
    drive(0, 1, 1);
    check("R1", {23'd0, smp_data, smp_valid}, 32'd0);

    // R10: mode not taken before the frame's last octet
    cfg_mode = 3'd1;
    drive(0, 0, 0);
    drive(1, 0, 0);
    for (int i = 0; i < FO - 1; i++) drive(1, 0, 1);
    drive(1, 0, 0);
    check("R10", {31'd0, smp_valid}, 32'd0);
    drive(1, 0, 1);
    drive(1, 0, 0);
    check("R10", {31'd0, smp_valid}, 32'd1);

    // R3: ramp through a full wrap
    for (int i = 0; i < 300; i++) drive(1, 1, 0);
    // R6: sample in the release cycle uses phase 0
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(1, 1, 0);
    check("R6", {24'd0, smp_data}, 32'd0);
    drive(1, 1, 0);
    check("R6", {24'd0, smp_data}, 32'd1);

    // R4 and R5
    set_mode(3'd2);
    for (int i = 0; i < 6; i++) drive(1, 1, 0);
    set_mode(3'd3);
    cfg_user_word = 8'hC3;
    for (int i = 0; i < 4; i++) drive(1, 1, 0);
    check("R5", {24'd0, smp_data}, 32'hC3);

    // R7: first octet from all-ones start is 0x02
    set_mode(3'd4);
    drive(1, 0, 1);
    check("R7", {24'd0, oct_data}, 32'h02);
    for (int i = 0; i < 40; i++) drive(1, 0, 1);
    set_mode(3'd5);
    for (int i = 0; i < 40; i++) drive(1, 0, 1);
    set_mode(3'd6);
    for (int i = 0; i < 40; i++) drive(1, 0, 1);
    // R10: reserved code maps to off
    set_mode(3'd7);
    check("R10", {30'd0, smp_valid, oct_valid}, 32'd0);
    // R11: data held with enables low
    drive(1, 0, 0);
    check("R11", {24'd0, oct_data}, {24'd0, e_od});

    // constrained random phase (R2, R3..R11 through the model)
    for (int blk = 0; blk < 40; blk++) begin
      cfg_mode = 3'($urandom_range(0, 7));
      cfg_user_word = 8'($urandom);
      for (int i = 0; i < 100; i++) begin
        logic s;
        s = ($urandom_range(0, 47) == 0) ? ~sync_n : sync_n;
        if (!sync_n && $urandom_range(0, 3) == 0) s = 1'b1;
        drive(s, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule